// File: doc/BRIEF.md
# Response Frame Builder

This block assembles the data frames a flash programming target sends back to its programmer. A client starts a frame by giving a payload byte count and a flag that says whether another frame of the same response will follow. The client then supplies the payload bytes, such as a status code or read-back data, through a valid/ready byte input. The block emits the frame one byte at a time through a valid/ready byte output, which normally feeds a UART transmitter.

Each frame is a fixed sequence: a header byte, the length byte, the payload, a checksum, and a footer. The checksum is built up while the bytes pass through, so no payload storage is needed. The footer tells the receiver whether the response continues in a further frame. While a frame is being sent, a busy output is high, and any new start request is dropped.

Top module: `resp_frame_gen`

## Requirements
- R1: An accepted frame is sent as header byte 0x02, then the length byte, then the payload bytes, then the checksum byte, then the footer byte. The header is presented on the output the cycle after busy_o rises.
- R2: The length byte is the requested count modulo 256. Counts run from 1 to 256, and a count of 256 is sent as 0x00.
- R3: The checksum byte equals 0x00 minus the length byte minus every payload byte, modulo 256.
- R4: The footer is 0x17 when more_i was high with the accepted start, and 0x03 otherwise.
- R5: Payload bytes leave unchanged and in arrival order, whatever their value. This includes the status codes 0x06, 0x15, 0x05, 0x0F, 0x10, 0x1A, 0x1B, 0x1C and 0xFF, and bytes equal to the framing codes. No byte is inserted or escaped.
- R6: start_i is taken only when busy_o is low and the count is nonzero. A start while busy, or with count 0, has no effect on the output or on busy_o.
- R7: busy_o rises on the edge that takes a start. It stays high until the edge on which the footer byte is accepted downstream, and it is low after that edge.
- R8: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o does not change.
- R9: pay_ready_o is high only in the payload phase. No payload byte is taken while idle or during the header, and no more than the requested count is taken.
- R10: During reset, busy_o, tx_valid_o and pay_ready_o are low.
- R11: When tx_ready_i and pay_valid_i stay high, the bytes of a frame are presented on consecutive cycles. A frame with N payload bytes ends N+5 cycles after its start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request |
| start_len_i | input | CNT_W (9) | Payload byte count, 1..MAX_LEN |
| start_more_i | input | 1 | Another frame follows this one |
| busy_o | output | 1 | Frame in progress |
| pay_valid_i | input | 1 | Payload byte valid |
| pay_data_i | input | 8 | Payload byte |
| pay_ready_o | output | 1 | Payload byte taken this cycle |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_ready_i | input | 1 | Downstream takes the byte |

## Verification
Two things can happen in the same cycle: the downstream side takes the byte that is held, and the next byte, often a payload byte pulled from the input, is loaded. Because pay_ready_o depends on tx_ready_i, the bench stalls tx_ready_i on a repeating pattern while it also leaves gaps in pay_valid_i. It then checks that every payload byte arrives exactly once and in order, and that a stalled byte does not change. The same runs hold pay_valid_i high before the start and after the last payload byte, so a byte taken outside the payload phase shows up as a shifted or extra payload.

// File: rtl/resp_frame_pkg.sv
package resp_frame_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] FR_HDR      = 8'h02;
  localparam logic [BYTE_W-1:0] FR_END_LAST = 8'h03;
  localparam logic [BYTE_W-1:0] FR_END_MORE = 8'h17;

  // status codes carried as payload
  localparam logic [BYTE_W-1:0] ST_ACK       = 8'h06;
  localparam logic [BYTE_W-1:0] ST_NACK      = 8'h15;
  localparam logic [BYTE_W-1:0] ST_PARAM_ERR = 8'h05;
  localparam logic [BYTE_W-1:0] ST_VFY_ERR   = 8'h0F;
  localparam logic [BYTE_W-1:0] ST_PROT_ERR  = 8'h10;
  localparam logic [BYTE_W-1:0] ST_ERS_ERR   = 8'h1A;
  localparam logic [BYTE_W-1:0] ST_BLANK_ERR = 8'h1B;
  localparam logic [BYTE_W-1:0] ST_WR_ERR    = 8'h1C;
  localparam logic [BYTE_W-1:0] ST_BUSY      = 8'hFF;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_LEN,
    PH_PAY,
    PH_SUM,
    PH_END
  } fr_phase_e;
endpackage

// File: rtl/resp_frame_csum.sv
module resp_frame_csum
  import resp_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sub_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] sum_o
);
  logic [BYTE_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (sub_i) acc_q <= acc_q - byte_i;
  end

  assign sum_o = acc_q;
endmodule

// File: rtl/resp_frame_obuf.sv
module resp_frame_obuf
  import resp_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  output logic              load_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_byte_o,
  input  logic              out_ready_i
);
  logic              valid_q;
  logic [BYTE_W-1:0] byte_q;

  // slot free when empty or being drained this cycle
  assign load_o = !valid_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else if (load_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) byte_q <= in_byte_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_byte_o  = byte_q;
endmodule

// File: rtl/resp_frame_ctrl.sv
module resp_frame_ctrl
  import resp_frame_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_go_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              more_i,
  input  logic              pay_valid_i,
  input  logic [BYTE_W-1:0] pay_data_i,
  input  logic              adv_i,
  input  logic [BYTE_W-1:0] csum_i,
  output logic              gen_valid_o,
  output logic [BYTE_W-1:0] gen_byte_o,
  output logic              pay_ready_o,
  output logic              active_o,
  output logic              csum_clr_o,
  output logic              csum_sub_o
);
  fr_phase_e         ph_q;
  logic [CNT_W-1:0]  rem_q;
  logic [BYTE_W-1:0] len_byte_q;
  logic              more_q;
  logic              fire;

  always_comb begin
    gen_byte_o = '0;
    unique case (ph_q)
      PH_HDR:  gen_byte_o = FR_HDR;
      PH_LEN:  gen_byte_o = len_byte_q;
      PH_PAY:  gen_byte_o = pay_data_i;
      PH_SUM:  gen_byte_o = csum_i;
      PH_END:  gen_byte_o = more_q ? FR_END_MORE : FR_END_LAST;
      default: gen_byte_o = '0;
    endcase
  end

  assign gen_valid_o = (ph_q != PH_IDLE) && ((ph_q != PH_PAY) || pay_valid_i);
  assign fire        = gen_valid_o && adv_i;
  assign pay_ready_o = (ph_q == PH_PAY) && adv_i;
  assign active_o    = (ph_q != PH_IDLE);
  assign csum_clr_o  = start_go_i;
  assign csum_sub_o  = fire && ((ph_q == PH_LEN) || (ph_q == PH_PAY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      rem_q      <= '0;
      len_byte_q <= '0;
      more_q     <= 1'b0;
    end else if (start_go_i) begin
      ph_q       <= PH_HDR;
      rem_q      <= len_i;
      len_byte_q <= len_i[BYTE_W-1:0];
      more_q     <= more_i;
    end else if (fire) begin
      unique case (ph_q)
        PH_HDR: ph_q <= PH_LEN;
        PH_LEN: ph_q <= PH_PAY;
        PH_PAY: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) ph_q <= PH_SUM;
        end
        PH_SUM: ph_q <= PH_END;
        PH_END: ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/resp_frame_gen.sv
module resp_frame_gen
  import resp_frame_pkg::*;
#(
  parameter int MAX_LEN = 256,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  start_len_i,
  input  logic              start_more_i,
  output logic              busy_o,
  input  logic              pay_valid_i,
  input  logic [BYTE_W-1:0] pay_data_i,
  output logic              pay_ready_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i
);
  logic              start_go, active, gen_valid, load, csum_clr, csum_sub;
  logic [BYTE_W-1:0] gen_byte, csum;

  assign busy_o   = active || tx_valid_o;
  assign start_go = start_i && !busy_o && (start_len_i != '0);

  resp_frame_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_go_i  (start_go),
    .len_i       (start_len_i),
    .more_i      (start_more_i),
    .pay_valid_i (pay_valid_i),
    .pay_data_i  (pay_data_i),
    .adv_i       (load),
    .csum_i      (csum),
    .gen_valid_o (gen_valid),
    .gen_byte_o  (gen_byte),
    .pay_ready_o (pay_ready_o),
    .active_o    (active),
    .csum_clr_o  (csum_clr),
    .csum_sub_o  (csum_sub)
  );

  resp_frame_csum i_csum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (csum_clr),
    .sub_i  (csum_sub),
    .byte_i (gen_byte),
    .sum_o  (csum)
  );

  resp_frame_obuf i_obuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (gen_valid),
    .in_byte_i   (gen_byte),
    .load_o      (load),
    .out_valid_o (tx_valid_o),
    .out_byte_o  (tx_data_o),
    .out_ready_i (tx_ready_i)
  );
endmodule

// File: rtl/resp_frame_chk.sv
module resp_frame_chk
  import resp_frame_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  start_len_i,
  input logic              busy_o,
  input logic              pay_ready_o,
  input logic              tx_valid_o,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              tx_ready_i
);
  assert_hdr_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> (tx_valid_o && tx_data_o == FR_HDR));

  assert_zero_len_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && start_len_i == '0) |=> !busy_o);

  assert_busy_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tx_valid_o && tx_ready_i &&
                            (tx_data_o == FR_END_LAST || tx_data_o == FR_END_MORE)));

  assert_tx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  assert_pay_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> busy_o);

  assert_reset_quiet_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !tx_valid_o && !pay_ready_o));
endmodule

bind resp_frame_gen resp_frame_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_len_i (start_len_i),
  .busy_o      (busy_o),
  .pay_ready_o (pay_ready_o),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .tx_ready_i  (tx_ready_i)
);

// File: tb/test_resp_frame_gen.sv
module test_resp_frame_gen;
  localparam int CNT_W = 9;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] start_len_i = '0;
  logic             start_more_i = 1'b0;
  logic             busy_o;
  logic             pay_valid_i = 1'b0;
  logic [7:0]       pay_data_i = '0;
  logic             pay_ready_o;
  logic             tx_valid_o;
  logic [7:0]       tx_data_o;
  logic             tx_ready_i = 1'b0;

  always #4 clk_i = ~clk_i;

  resp_frame_gen i_resp_frame_gen (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int wd_cyc  = 0;

  logic [7:0] pay [256];
  logic [7:0] rx  [260];

  typedef struct packed {
    logic [8:0]  len;
    logic        more;
    logic        stall;
    logic        gap;
    logic [31:0] bytes;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{9'd1, 1'b0, 1'b0, 1'b0, 32'h06000000},
    '{9'd1, 1'b1, 1'b0, 1'b0, 32'h15000000},
    '{9'd2, 1'b0, 1'b1, 1'b0, 32'h050F0000},
    '{9'd4, 1'b1, 1'b1, 1'b1, 32'h101A1B1C},
    '{9'd3, 1'b0, 1'b0, 1'b1, 32'hFF020300},
    '{9'd4, 1'b0, 1'b1, 1'b1, 32'h170100FF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    wd_cyc++;
    if (wd_cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", wd_cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  task automatic run_frame(input int len, input bit more, input bit stall,
                           input bit gap, input bit poke);
    int  n = 0, pidx = 0, cyc = 0;
    bit  hold = 0, busy_ok = 1, over = 0, done = 0;
    logic [7:0] hold_d = '0;
    logic [7:0] sum;
    // R9: payload offered while idle must not be taken
    @(negedge clk_i);
    pay_valid_i = 1'b1;
    pay_data_i  = 8'hEE;
    tx_ready_i  = 1'b1;
    start_i     = 1'b1;
    start_len_i = CNT_W'(len);
    start_more_i = more;
    #1;
    chk(!pay_ready_o, "R9 idle pay_ready", pay_ready_o, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    start_more_i = ~more;
    chk(busy_o, "R7 busy after start", busy_o, 1);
    while (!done && cyc < 3000) begin
      tx_ready_i  = stall ? ((cyc % 3) != 1) : 1'b1;
      pay_valid_i = gap ? ((cyc % 4) != 2) : 1'b1;
      pay_data_i  = (pidx < len) ? pay[pidx] : 8'hEE;
      if (poke) begin
        start_i     = (cyc == 3);
        start_len_i = 9'd5;
      end
      #1;
      if (hold) begin
        if (!(tx_valid_o && tx_data_o == hold_d)) begin
          chk(0, "R8 hold under stall", tx_data_o, hold_d);
        end
      end
      if (!busy_o) busy_ok = 0;
      if (pay_ready_o && pay_valid_i) begin
        if (pidx >= len) over = 1;
        pidx++;
      end
      if (tx_valid_o && tx_ready_i) begin
        rx[n] = tx_data_o;
        n++;
        if (n == len + 4) done = 1;
      end
      hold   = tx_valid_o && !tx_ready_i;
      hold_d = tx_data_o;
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      cyc++;
    end
    pay_valid_i = 1'b0;
    tx_ready_i  = 1'b0;
    chk(busy_ok, "R7 busy held in frame", busy_ok, 1);
    chk(!busy_o, "R7 busy low after footer", busy_o, 0);
    chk(!over && pidx == len, "R9 payload count", pidx, len);
    chk(rx[0] == 8'h02, "R1 header", rx[0], 8'h02);
    chk(rx[1] == len[7:0], "R2 length byte", rx[1], len[7:0]);
    sum = 8'h00 - len[7:0];
    for (int k = 0; k < len; k++) begin
      sum = sum - pay[k];
      if (rx[2+k] != pay[k]) chk(0, "R5 payload", rx[2+k], pay[k]);
    end
    chk(1, "R5 payload order", 0, 0);
    chk(rx[len+2] == sum, "R3 checksum", rx[len+2], sum);
    chk(rx[len+3] == (more ? 8'h17 : 8'h03), "R4 footer", rx[len+3], more ? 8'h17 : 8'h03);
    if (!stall && !gap) chk(cyc == len + 5, "R11 full rate", cyc, len + 5);
    // R6: nothing follows a frame, including after a poked start
    repeat (4) @(negedge clk_i);
    chk(!busy_o && !tx_valid_o, "R6 no stray frame", busy_o, 0);
  endtask

  initial begin
    #1;
    chk(!busy_o && !tx_valid_o && !pay_ready_o, "R10 reset outputs",
        {busy_o, tx_valid_o, pay_ready_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    foreach (VECS[i]) begin
      for (int k = 0; k < 4; k++) pay[k] = VECS[i].bytes[31-8*k -: 8];
      run_frame(int'(VECS[i].len), VECS[i].more, VECS[i].stall, VECS[i].gap, 1'b0);
    end

    // R2: 256 bytes sent as length 0x00
    for (int k = 0; k < 256; k++) pay[k] = 8'(k * 7 + 3);
    run_frame(256, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame(256, 1'b0, 1'b1, 1'b1, 1'b0);

    // R6: start while busy ignored
    pay[0] = 8'h1B; pay[1] = 8'h1C; pay[2] = 8'h06;
    run_frame(3, 1'b0, 1'b1, 1'b0, 1'b1);

    // R6: zero count ignored
    @(negedge clk_i);
    start_i = 1'b1;
    start_len_i = '0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!busy_o, "R6 zero length ignored busy", busy_o, 0);
    repeat (2) @(negedge clk_i);
    chk(!tx_valid_o, "R6 zero length no output", tx_valid_o, 0);

    // R10: reset in mid frame
    pay[0] = 8'hFF;
    @(negedge clk_i);
    start_i = 1'b1;
    start_len_i = 9'd1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !tx_valid_o && !pay_ready_o, "R10 reset mid frame",
        {busy_o, tx_valid_o, pay_ready_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_frame(1, 1'b1, 1'b0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule